// File: doc/BRIEF.md
# Start-Stop Link Delay Timer

This block measures the delay of a serial link with single-bit resolution. It builds the 20-bit transmit words for a link that runs 8b/10b-coded characters at two characters per word. Between measurements it sends an endless idle pattern. On request it puts a marker word in place of one idle word. A word counter starts on the clock edge that hands the marker to the serializer. It stops on the edge at which the aligned receive stream shows the same marker again.

Counting words alone resolves the arrival only to one word period, which is 6.4 ns at 3.125 Gb/s. To reach single-bit resolution, the block adds the bit-slip position that the receive word aligner settled on. The result is reported as words × 20 + slip, in units of one bit period (320 ps at that line rate).

The transmit and receive words are clocked by isochronous clocks. Both are treated here as the single block clock `clk`, with an unknown but fixed phase offset between them. The receive side has no back-pressure. Each word presented with `rx_valid` is looked at once.

The transmit output follows valid/ready rules. `tx_valid` is high at every edge after reset. A word moves on only at an edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_data` holds its value. The counter starts from the edge at which the marker word is accepted, so any stall before that edge does not count as delay.

Top module: `link_delay_timer`

## Requirements
- R1: Out of reset and between measurements, every transmit word is the idle set, with the first character in bits [19:10]. That is 0011111010 (comma character, negative disparity) in bits [19:10], then 1001000101 (disparity-restoring data character) in bits [9:0]. The pattern keeps running disparity negative.
- R2: Each accepted request puts exactly one marker word into the transmit stream: 1110101000 in bits [19:10] and the neutral character 1010101010 in bits [9:0].
- R3: While `tx_valid` is high and `tx_ready` is low, `tx_data` does not change.
- R4: `busy` goes high one edge after a `meas_req` that is accepted. It stays high until the edge that raises `done` or `timeout`, and falls on that edge.
- R5: The marker is seen when `rx_valid` is high and `rx_data[19:10]` equals either 1110101000 or 0001010111. Call N the number of edges from the marker's transmit acceptance to the edge at which it is seen (N ≥ 1). On that edge `done` pulses for one cycle and `delay_bits` becomes N×20 + `rx_slip`.
- R6: A `meas_req` raised while `busy` is high is ignored: no further marker is sent.
- R7: An `rx_slip` value above 19 is treated as 19 in the result.
- R8: A marker on the receive side while `busy` is low produces no `done`, no `timeout` and no change of `busy`.
- R9: If no marker returns, `timeout` pulses on the edge that is 2^CNT_W − 1 edges after the transmit acceptance, and the measurement ends without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock shared by the transmit and receive sides |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_req | input | 1 | Request a measurement (taken only while idle) |
| tx_data | output | 20 | Transmit word, first character in [19:10] |
| tx_valid | output | 1 | Transmit word valid (high after reset) |
| tx_ready | input | 1 | Serializer accepts the word |
| rx_data | input | 20 | Aligned receive word, first character in [19:10] |
| rx_valid | input | 1 | Receive word present |
| rx_slip | input | 5 | Bit-slip position chosen by the word aligner |
| busy | output | 1 | Measurement pending or running |
| done | output | 1 | One-cycle pulse: `delay_bits` updated |
| timeout | output | 1 | One-cycle pulse: marker never returned |
| delay_bits | output | CNT_W+5 | Measured delay in bit periods |

## Verification
The bench builds the block with CNT_W = 8, so the counter saturates after 255 words. At the default width, saturation lies beyond any practical run length, and the narrow width brings the timeout path and its exact firing cycle within reach. With CNT_W = 8, round trips of 1 to several dozen words sit well inside the counter range. This lets the bench try the smallest delay, both marker disparities, slip values at and above the top of the range, and a stall of the serializer just before launch.

// File: rtl/ldt_pkg.sv
package ldt_pkg;
  localparam int CHAR_W = 10;
  localparam int WORD_W = 2 * CHAR_W;

  // 8b/10b codes used by the pattern, written out as transmitted bit groups
  localparam logic [CHAR_W-1:0] COMMA_NEG   = 10'b0011111010;
  localparam logic [CHAR_W-1:0] FILL_POS    = 10'b1001000101;
  localparam logic [CHAR_W-1:0] MARK_NEG    = 10'b1110101000;
  localparam logic [CHAR_W-1:0] MARK_POS    = 10'b0001010111;
  localparam logic [CHAR_W-1:0] MARK_FOLLOW = 10'b1010101010;

  localparam logic [WORD_W-1:0] IDLE_WORD = {COMMA_NEG, FILL_POS};
  localparam logic [WORD_W-1:0] MARK_WORD = {MARK_NEG, MARK_FOLLOW};
endpackage

// File: rtl/ldt_tx_gen.sv
module ldt_tx_gen
  import ldt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_valid,
  output logic              launch,
  output logic              in_flight
);
  logic pending;  // request seen, marker not yet loaded
  logic armed;    // marker sits in the output register
  logic accept;

  assign accept    = tx_valid && tx_ready;
  assign launch    = accept && armed;
  assign in_flight = pending || armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= IDLE_WORD;
      pending  <= 1'b0;
      armed    <= 1'b0;
    end else begin
      tx_valid <= 1'b1;
      if (accept) begin
        tx_data <= pending ? MARK_WORD : IDLE_WORD;
        armed   <= pending;
        pending <= start_req;
      end else if (start_req) begin
        pending <= 1'b1;
      end
    end
  end

  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> $stable(tx_data));

  p_single_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !launch);
endmodule

// File: rtl/ldt_mark_det.sv
module ldt_mark_det
  import ldt_pkg::*;
(
  input  logic [WORD_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              seen
);
  logic [CHAR_W-1:0] lead;

  assign lead = rx_data[WORD_W-1 -: CHAR_W];

  always_comb begin
    seen = 1'b0;
    if (rx_valid && (lead == MARK_NEG || lead == MARK_POS)) seen = 1'b1;
  end
endmodule

// File: rtl/ldt_timer.sv
module ldt_timer
  import ldt_pkg::*;
#(
  parameter int CNT_W  = 18,
  parameter int SLIP_W = 5,
  localparam int RES_W = CNT_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              seen,
  input  logic [SLIP_W-1:0] slip,
  output logic              running,
  output logic              done,
  output logic              timeout,
  output logic [RES_W-1:0]  delay_bits
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [SLIP_W-1:0] SLIP_TOP = SLIP_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [SLIP_W-1:0] slip_c;
  logic [RES_W-1:0]  total;

  always_comb begin
    slip_c = (slip > SLIP_TOP) ? SLIP_TOP : slip;
    total  = RES_W'(cnt) * RES_W'(WORD_W) + RES_W'(slip_c);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running    <= 1'b0;
      cnt        <= '0;
      done       <= 1'b0;
      timeout    <= 1'b0;
      delay_bits <= '0;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      if (running) begin
        if (seen) begin
          done       <= 1'b1;
          delay_bits <= total;
          running    <= 1'b0;
        end else if (cnt == CNT_MAX) begin
          timeout <= 1'b1;
          running <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (launch) begin
        running <= 1'b1;
        cnt     <= CNT_W'(1);
      end
    end
  end

  p_cnt_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt != '0));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_end_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));
endmodule

// File: rtl/link_delay_timer.sv
module link_delay_timer
  import ldt_pkg::*;
#(
  parameter int CNT_W = 18,
  localparam int SLIP_W = 5,
  localparam int RES_W  = CNT_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              meas_req,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              rx_valid,
  input  logic [SLIP_W-1:0] rx_slip,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic [RES_W-1:0]  delay_bits
);
  logic req_ok, launch, in_flight, seen, running;

  assign busy   = in_flight || running;
  assign req_ok = meas_req && !busy;

  ldt_tx_gen u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (req_ok),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .launch    (launch),
    .in_flight (in_flight)
  );

  ldt_mark_det u_det (
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .seen     (seen)
  );

  ldt_timer #(.CNT_W(CNT_W), .SLIP_W(SLIP_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .seen       (seen && running),
    .slip       (rx_slip),
    .running    (running),
    .done       (done),
    .timeout    (timeout),
    .delay_bits (delay_bits)
  );

  p_busy_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || timeout));

  p_busy_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ok |=> busy);
endmodule

// File: tb/link_delay_timer_test.sv
module link_delay_timer_test;
  localparam int CW = 8;
  localparam logic [19:0] IDLE = {10'b0011111010, 10'b1001000101};
  localparam logic [19:0] MARK = {10'b1110101000, 10'b1010101010};
  localparam logic [19:0] MARK_ALT = {10'b0001010111, 10'b1010101010};

  logic clk = 0, rst_n = 0, meas_req = 0, tx_ready = 1, rx_valid = 1;
  logic [19:0] tx_data, rx_data = IDLE;
  logic tx_valid, busy, done, timeout;
  logic [4:0] rx_slip = 0;
  logic [CW+4:0] delay_bits;

  int checks = 0, fails = 0, mark_cnt = 0;
  int exp_q[$];
  bit finished = 0;

  always #4 clk = ~clk;

  link_delay_timer #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .meas_req(meas_req), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_slip(rx_slip), .busy(busy), .done(done),
    .timeout(timeout), .delay_bits(delay_bits));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: marker launches and scoreboard of results
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready && tx_data == MARK) mark_cnt++;
    if (rst_n && done) begin
      int e;
      if (exp_q.size() == 0) chk(0, "R5 unexpected done", delay_bits, -1);
      else begin
        e = exp_q.pop_front();
        chk(delay_bits == e, "R5 scoreboard delay", delay_bits, e);
      end
    end
  end

  task automatic pulse_req();
    @(negedge clk) meas_req = 1;
    @(negedge clk) meas_req = 0;
  endtask

  task automatic find_launch();
    int g = 0;
    forever begin
      @(negedge clk);
      if (tx_valid && tx_ready && tx_data == MARK) break;
      g++;
      if (g > 50) begin chk(0, "R2 marker never sent", 0, 1); break; end
    end
    @(posedge clk);
  endtask

  task automatic measure(input int n, input logic [4:0] slip, input bit alt,
                         input bit poke, input bit stall, input string tag);
    int m0 = mark_cnt;
    int e = n * 20 + ((slip > 19) ? 19 : slip);
    pulse_req();
    chk(busy == 1, "R4 busy after request", busy, 1);
    if (stall) begin
      logic [19:0] w;
      tx_ready = 0;
      @(negedge clk) w = tx_data;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        chk(tx_data == w, "R3 word held under stall", tx_data, w);
      end
      tx_ready = 1;
    end
    find_launch();
    exp_q.push_back(e);
    for (int i = 1; i < n; i++) begin
      @(posedge clk);
      #1 meas_req = (poke && i == 1);
    end
    @(negedge clk);
    meas_req = 0;
    rx_data = alt ? MARK_ALT : MARK;
    rx_slip = slip;
    @(posedge clk);
    @(negedge clk);
    chk(done == 1, {tag, " done pulse"}, done, 1);
    chk(delay_bits == e, {tag, " delay"}, delay_bits, e);
    rx_data = IDLE;
    rx_slip = 0;
    chk(busy == 0, "R4 busy cleared", busy, 0);
    repeat (10) @(negedge clk);
    chk(mark_cnt == m0 + 1, poke ? "R6 extra request ignored" : "R2 one marker",
        mark_cnt, m0 + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(busy == 0 && done == 0 && timeout == 0, "R4 reset state", busy, 0);
    chk(tx_data == IDLE, "R1 idle after reset", tx_data, IDLE);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(tx_data == IDLE && tx_valid, "R1 idle pattern", tx_data, IDLE);
    end

    measure(5, 5'd0, 0, 0, 0, "R5 n5");
    measure(1, 5'd19, 0, 0, 0, "R5 n1 slip19");
    measure(37, 5'd7, 0, 0, 0, "R5 n37");
    measure(12, 5'd3, 1, 0, 0, "R5 other disparity");
    measure(9, 5'd25, 0, 0, 0, "R7 slip clamp");
    measure(20, 5'd31, 1, 0, 0, "R7 slip max");
    measure(15, 5'd11, 0, 1, 0, "R6 poke");
    measure(6, 5'd2, 0, 0, 1, "R3 stall");

    // R8: stray marker while idle
    @(negedge clk) rx_data = MARK;
    @(negedge clk);
    chk(done == 0 && timeout == 0 && busy == 0, "R8 stray marker ignored", done, 0);
    rx_data = IDLE;
    @(negedge clk);
    chk(tx_data == IDLE, "R1 idle between measurements", tx_data, IDLE);

    // R9: timeout
    begin
      int k = 0;
      pulse_req();
      find_launch();
      forever begin
        @(posedge clk);
        k++;
        @(negedge clk);
        if (timeout || done || k > 400) break;
      end
      chk(timeout == 1 && done == 0, "R9 timeout raised", timeout, 1);
      chk(k == 255, "R9 timeout cycle", k, 255);
      @(negedge clk);
      chk(busy == 0 && timeout == 0, "R9 measurement ended", busy, 0);
    end

    measure(3, 5'd4, 0, 0, 0, "R5 after timeout");
    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule